// File: doc/BRIEF.md
# Serial LCD Command and Segment Loader

This block sits between a host's serial link and the control side of a multiplexed LCD controller. The host presents one bit per qualified rising edge of the serial clock, with the most significant bit first. The loader groups these bits into a word. The first eight bits of a word are a command byte. The remaining bits are segment data bound for the display RAM. Nothing is released halfway through a word. When the last bit of the selected word length arrives, the command byte moves into its register and the segment bits are presented with a write strobe. A one-cycle completion pulse marks each accepted word.

Three word lengths are available: a long 128-bit word, and two short forms of 32 and 8 bits. The 8-bit form carries only a command byte. Two active-low reset inputs are provided, and both pass through a two-flop synchronizer. The register reset clears every register in the loader. The counter reset only abandons a partial word and re-arms the bit counter. This lets a host recover from an interrupted transfer without losing the command already loaded or the segment data last written.

Top module: `serial_lcd_loader`

## Requirements
- R1: The word length follows `word_mode`: 2'b00 and 2'b11 select 128 bits, 2'b01 selects 32 bits, and 2'b10 selects 8 bits.
- R2: A bit is taken only on a rising edge where `bit_en` is high. Bits arrive most significant first, and edges with `bit_en` low do not advance the word.
- R3: `cmd_q` receives the first eight bits of the word. The first bit received goes to `cmd_q[7]`.
- R4: For a word of length L greater than 8, `seg_wdata` takes the L-8 payload bits right-aligned. The last bit received lands in bit 0, the first payload bit lands in bit L-9, and all bits above it are zero.
- R5: `seg_we` is high only together with `done`, and only for words longer than 8 bits. `seg_wdata` changes only when `seg_we` is high, or when the register reset clears it.
- R6: `done` is a single-cycle pulse. It goes high in the cycle after the edge that takes the final bit of a word.
- R7: The word length is sampled on the first bit of each word. A change of `word_mode` later in the same word has no effect on that word.
- R8: A low pulse on `cnt_rst_n` takes effect on the second rising edge after it is sampled. It discards any partial word. It leaves `cmd_q` and `seg_wdata` unchanged, and the next word is assembled from its own first bit.
- R9: If the counter reset takes effect on the same edge as the final bit of a word, the counter reset wins. No `done` pulse follows, and `cmd_q` is not updated.
- R10: A low pulse on `reg_rst_n` takes effect on the second rising edge after it is sampled. It clears `cmd_q`, `seg_wdata`, `done`, `seg_we` and any partial word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock; data is sampled on its rising edge |
| reg_rst_n | input | 1 | Active-low register reset, asynchronous to clk |
| cnt_rst_n | input | 1 | Active-low counter-only reset, asynchronous to clk |
| bit_en | input | 1 | Qualifies the current edge as carrying a data bit |
| sdi | input | 1 | Serial data bit |
| word_mode | input | 2 | Word length select, sampled on the first bit of a word |
| cmd_q | output | 8 | Command register |
| seg_wdata | output | 120 | Segment payload for the display RAM |
| seg_we | output | 1 | Write strobe for `seg_wdata` |
| done | output | 1 | One-cycle pulse when a full word has been committed |

## Verification
The counter reset and the completion of a word can land on the same edge. The bench drives `cnt_rst_n` low together with the third-to-last bit of a 128-bit word and a 32-bit word. After the two synchronizer stages, the reset therefore reaches the loader on exactly the edge that takes the final bit. The outcome is correct only if no `done` appears, the scoreboard queue stays empty, `cmd_q` keeps its earlier value, and the next complete word is accepted cleanly from its first bit.

// File: rtl/lcd_ld_pkg.sv
package lcd_ld_pkg;

    typedef enum logic [1:0] {
        LEN_FULL  = 2'b00,
        LEN_MID   = 2'b01,
        LEN_SHORT = 2'b10,
        LEN_ALT   = 2'b11
    } len_sel_e;

    function automatic int unsigned sel_len(
        input len_sel_e    s,
        input int unsigned full_len,
        input int unsigned mid_len,
        input int unsigned short_len
    );
        case (s)
            LEN_MID:   return mid_len;
            LEN_SHORT: return short_len;
            default:   return full_len;
        endcase
    endfunction

endpackage

// File: rtl/lcd_rst_sync.sv
module lcd_rst_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic in_n,
    output logic rst
);
    logic [STAGES-1:0] sy;

    always_ff @(posedge clk) begin
        sy <= {sy[STAGES-2:0], in_n};
    end

    assign rst = ~sy[STAGES-1];
endmodule

// File: rtl/lcd_bit_framer.sv
module lcd_bit_framer
    import lcd_ld_pkg::*;
#(
    parameter int WORD_MAX  = 128,
    parameter int MID_LEN   = 32,
    parameter int SHORT_LEN = 8,
    parameter int LEN_W     = $clog2(WORD_MAX + 1)
) (
    input  logic             clk,
    input  logic             clr,
    input  logic             bit_en,
    input  logic [1:0]       mode,
    output logic             last_bit,
    output logic [LEN_W-1:0] cnt,
    output logic [LEN_W-1:0] cur_len
);
    localparam logic [LEN_W-1:0] FULL_LEN = LEN_W'(WORD_MAX);

    logic [LEN_W-1:0] new_len;

    assign new_len  = LEN_W'(sel_len(len_sel_e'(mode), WORD_MAX, MID_LEN, SHORT_LEN));
    assign last_bit = bit_en && (cnt != '0) && (cnt == cur_len - LEN_W'(1));

    always_ff @(posedge clk) begin
        if (clr) begin
            cnt     <= '0;
            cur_len <= FULL_LEN;
        end else if (bit_en) begin
            if (cnt == '0) cur_len <= new_len;
            if (last_bit) cnt <= '0;
            else          cnt <= cnt + LEN_W'(1);
        end
    end
endmodule

// File: rtl/lcd_frame_shift.sv
module lcd_frame_shift #(
    parameter int WORD_MAX = 128
) (
    input  logic                clk,
    input  logic                clr,
    input  logic                bit_en,
    input  logic                last_bit,
    input  logic                sdi,
    output logic [WORD_MAX-1:0] frame_next
);
    logic [WORD_MAX-2:0] sr;

    assign frame_next = {sr, sdi};

    always_ff @(posedge clk) begin
        if (clr) begin
            sr <= '0;
        end else if (bit_en) begin
            if (last_bit) sr <= '0;
            else          sr <= frame_next[WORD_MAX-2:0];
        end
    end
endmodule

// File: rtl/serial_lcd_loader.sv
module serial_lcd_loader #(
    parameter int WORD_MAX  = 128,
    parameter int MID_LEN   = 32,
    parameter int SHORT_LEN = 8,
    parameter int CMD_W     = 8,
    parameter int SYNC_ST   = 2
) (
    input  logic                      clk,
    input  logic                      reg_rst_n,
    input  logic                      cnt_rst_n,
    input  logic                      bit_en,
    input  logic                      sdi,
    input  logic [1:0]                word_mode,
    output logic [CMD_W-1:0]          cmd_q,
    output logic [WORD_MAX-CMD_W-1:0] seg_wdata,
    output logic                      seg_we,
    output logic                      done
);
    localparam int PAY_W = WORD_MAX - CMD_W;
    localparam int LEN_W = $clog2(WORD_MAX + 1);
    localparam int IDX_W = $clog2(WORD_MAX);
    localparam logic [LEN_W-1:0] CMD_LEN = LEN_W'(CMD_W);

    // index 0: register reset, index 1: counter reset
    logic [1:0] rst_in_n;
    logic [1:0] rst_sy;
    assign rst_in_n = {cnt_rst_n, reg_rst_n};

    for (genvar g = 0; g < 2; g++) begin : g_sync
        lcd_rst_sync #(.STAGES(SYNC_ST)) u_sync (
            .clk  (clk),
            .in_n (rst_in_n[g]),
            .rst  (rst_sy[g])
        );
    end

    logic rst_reg_q, rst_cnt_q, clr_any;
    assign rst_reg_q = rst_sy[0];
    assign rst_cnt_q = rst_sy[1];
    assign clr_any   = rst_reg_q | rst_cnt_q;

    logic             last_bit;
    logic [LEN_W-1:0] fr_cnt, fr_len;
    logic [WORD_MAX-1:0] frame_next;

    lcd_bit_framer #(
        .WORD_MAX (WORD_MAX),
        .MID_LEN  (MID_LEN),
        .SHORT_LEN(SHORT_LEN),
        .LEN_W    (LEN_W)
    ) u_framer (
        .clk      (clk),
        .clr      (clr_any),
        .bit_en   (bit_en),
        .mode     (word_mode),
        .last_bit (last_bit),
        .cnt      (fr_cnt),
        .cur_len  (fr_len)
    );

    lcd_frame_shift #(.WORD_MAX(WORD_MAX)) u_shift (
        .clk        (clk),
        .clr        (clr_any),
        .bit_en     (bit_en),
        .last_bit   (last_bit),
        .sdi        (sdi),
        .frame_next (frame_next)
    );

    logic             commit, has_pay;
    logic [IDX_W-1:0] cmd_hi;
    logic [LEN_W-1:0] shamt;
    logic [PAY_W-1:0] pay_mask, pay_next;
    logic [CMD_W-1:0] cmd_next;

    assign commit   = last_bit & ~clr_any;
    assign has_pay  = fr_len > CMD_LEN;
    assign cmd_hi   = IDX_W'(fr_len - LEN_W'(1));
    assign shamt    = fr_len - CMD_LEN;
    assign cmd_next = frame_next[cmd_hi -: CMD_W];
    assign pay_mask = ~({PAY_W{1'b1}} << shamt);
    assign pay_next = frame_next[PAY_W-1:0] & pay_mask;

    always_ff @(posedge clk) begin
        if (rst_reg_q) begin
            cmd_q     <= '0;
            seg_wdata <= '0;
            seg_we    <= 1'b0;
            done      <= 1'b0;
        end else begin
            done   <= commit;
            seg_we <= commit & has_pay;
            if (commit) cmd_q <= cmd_next;
            if (commit && has_pay) seg_wdata <= pay_next;
        end
    end
endmodule

// File: rtl/serial_lcd_loader_chk.sv
module serial_lcd_loader_chk #(
    parameter int CMD_W = 8,
    parameter int PAY_W = 120,
    parameter int LEN_W = 8
) (
    input logic             clk,
    input logic             rst_reg,
    input logic             rst_cnt,
    input logic             done,
    input logic             seg_we,
    input logic [CMD_W-1:0] cmd,
    input logic [PAY_W-1:0] seg_wdata,
    input logic [LEN_W-1:0] bit_cnt,
    input logic [LEN_W-1:0] cur_len
);
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst_reg)
        bit_cnt < cur_len); // R1

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst_reg)
        done |=> !done); // R6

    AST_WE_WITH_DONE: assert property (@(posedge clk) disable iff (rst_reg)
        seg_we |-> done); // R5

    AST_SEG_HOLD: assert property (@(posedge clk) disable iff (rst_reg)
        (!seg_we && !$past(rst_reg)) |-> $stable(seg_wdata)); // R5

    AST_CMD_HOLD: assert property (@(posedge clk) disable iff (rst_reg)
        (!done && !$past(rst_reg)) |-> $stable(cmd)); // R8

    AST_CNT_RST_WINS: assert property (@(posedge clk) disable iff (rst_reg)
        rst_cnt |=> !done); // R9
endmodule

bind serial_lcd_loader serial_lcd_loader_chk #(
    .CMD_W(CMD_W),
    .PAY_W(PAY_W),
    .LEN_W(LEN_W)
) u_chk (
    .clk       (clk),
    .rst_reg   (rst_reg_q),
    .rst_cnt   (rst_cnt_q),
    .done      (done),
    .seg_we    (seg_we),
    .cmd       (cmd_q),
    .seg_wdata (seg_wdata),
    .bit_cnt   (fr_cnt),
    .cur_len   (fr_len)
);

// File: tb/serial_lcd_loader_test.sv
module serial_lcd_loader_test;
    logic         clk = 1'b0;
    logic         reg_rst_n, cnt_rst_n, bit_en, sdi;
    logic [1:0]   word_mode;
    logic [7:0]   cmd_q;
    logic [119:0] seg_wdata;
    logic         seg_we, done;

    int total = 0;
    int bad   = 0;

    typedef struct {
        logic [7:0]   cmd;
        logic [119:0] pay;
        logic         we;
    } exp_t;

    exp_t         q[$];
    logic [7:0]   m_cmd = '0;
    logic [119:0] m_pay = '0;

    always #4 clk = ~clk;

    serial_lcd_loader uut (
        .clk(clk), .reg_rst_n(reg_rst_n), .cnt_rst_n(cnt_rst_n),
        .bit_en(bit_en), .sdi(sdi), .word_mode(word_mode),
        .cmd_q(cmd_q), .seg_wdata(seg_wdata), .seg_we(seg_we), .done(done)
    );

    task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // monitor: compare each committed word against the scoreboard
    always @(negedge clk) begin
        if (done) begin
            if (q.size() == 0) begin
                check(1'b0, "R9/R6 unexpected done", 128'(done), 128'(0));
            end else begin
                exp_t e;
                e = q.pop_front();
                check(cmd_q == e.cmd, "R3 cmd", 128'(cmd_q), 128'(e.cmd));
                check(seg_wdata == e.pay, "R4 payload", 128'(seg_wdata), 128'(e.pay));
                check(seg_we == e.we, "R5 seg_we", 128'(seg_we), 128'(e.we));
            end
        end
    end

    // drives a word; kill_at >= 0 pulses cnt_rst_n with that bit
    task automatic send_word(input logic [127:0] w, input int len, input logic [1:0] mode,
                             input logic [1:0] alt_mode, input bit gaps, input int kill_at,
                             input bit commit);
        if (commit) begin
            exp_t e;
            logic [127:0] t;
            t = w >> (len - 8);
            e.cmd = t[7:0];
            if (len > 8) begin
                t = w & ((128'd1 << (len - 8)) - 128'd1);
                m_pay = t[119:0];
            end
            m_cmd = e.cmd;
            e.pay = m_pay;
            e.we  = (len > 8);
            q.push_back(e);
        end
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            if (gaps && (i % 3 == 1)) begin
                bit_en = 1'b0;
                sdi    = ~w[len-1-i];
                @(negedge clk);
            end
            bit_en    = 1'b1;
            sdi       = w[len-1-i];
            word_mode = (i == 0) ? mode : alt_mode;
            cnt_rst_n = (i == kill_at) ? 1'b0 : 1'b1;
        end
        @(negedge clk);
        bit_en    = 1'b0;
        cnt_rst_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "watchdog", 128'(0), 128'(1));
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        reg_rst_n = 1'b0; cnt_rst_n = 1'b0; bit_en = 1'b0; sdi = 1'b0; word_mode = 2'b00;
        repeat (5) @(negedge clk);
        reg_rst_n = 1'b1; cnt_rst_n = 1'b1;
        repeat (4) @(negedge clk);
        // R10 reset state
        check(cmd_q == 8'h0, "R10 cmd reset", 128'(cmd_q), 128'(0));
        check(seg_wdata == '0, "R10 seg reset", 128'(seg_wdata), 128'(0));
        check(!done && !seg_we, "R10 strobes reset", 128'({done, seg_we}), 128'(0));

        // R1 R2 R3 R4 R6: long words, two patterns
        send_word({32'hA5C3_0F1E, 32'h1234_5678, 32'hDEAD_BEEF, 32'h8001_7FFE}, 128, 2'b00, 2'b00, 1'b0, -1, 1'b1);
        send_word({32'h5A00_FFFF, 32'h0000_0001, 32'hCAFE_F00D, 32'h0F0F_F0F0}, 128, 2'b00, 2'b00, 1'b1, -1, 1'b1);
        // R1: mode 3 is also the long length
        send_word({32'h3C96_6996, 32'hFFFF_0000, 32'h1357_9BDF, 32'h2468_ACE0}, 128, 2'b11, 2'b11, 1'b0, -1, 1'b1);
        // R1 R2: 32-bit word with idle gaps
        send_word(128'h0000_0000_0000_0000_0000_0000_C7AB_CDEF, 32, 2'b01, 2'b01, 1'b1, -1, 1'b1);
        // R5: 8-bit word updates cmd only, payload held
        send_word(128'h96, 8, 2'b10, 2'b10, 1'b0, -1, 1'b1);
        // R7: mode switched to 8 after first bit, still a 32-bit word
        send_word(128'h0000_0000_0000_0000_0000_0000_E1F0_0A55, 32, 2'b01, 2'b10, 1'b0, -1, 1'b1);

        // R8: partial word abandoned by counter reset
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            bit_en = 1'b1; sdi = i[0]; word_mode = 2'b00;
        end
        @(negedge clk);
        bit_en = 1'b0; cnt_rst_n = 1'b0;
        @(negedge clk);
        cnt_rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check(cmd_q == m_cmd, "R8 cmd kept", 128'(cmd_q), 128'(m_cmd));
        check(seg_wdata == m_pay, "R8 seg kept", 128'(seg_wdata), 128'(m_pay));
        send_word(128'h0000_0000_0000_0000_0000_0000_4B12_3456, 32, 2'b01, 2'b01, 1'b0, -1, 1'b1);

        // R9: counter reset lands on the final bit edge
        send_word({32'h7777_8888, 32'h0, 32'h1, 32'h2}, 128, 2'b00, 2'b00, 1'b0, 125, 1'b0);
        check(cmd_q == m_cmd, "R9 cmd unchanged", 128'(cmd_q), 128'(m_cmd));
        check(q.size() == 0, "R9 no commit", 128'(q.size()), 128'(0));
        send_word(128'h0000_0000_0000_0000_0000_0000_D200_00FF, 32, 2'b01, 2'b01, 1'b0, 29, 1'b0);
        check(cmd_q == m_cmd, "R9 short word cmd unchanged", 128'(cmd_q), 128'(m_cmd));
        send_word(128'h0000_0000_0000_0000_0000_0000_2C5A_A5C2, 32, 2'b01, 2'b01, 1'b0, -1, 1'b1);

        // R10: register reset clears outputs
        @(negedge clk);
        reg_rst_n = 1'b0;
        @(negedge clk);
        reg_rst_n = 1'b1;
        repeat (4) @(negedge clk);
        m_cmd = '0; m_pay = '0;
        check(cmd_q == 8'h0, "R10 cmd cleared", 128'(cmd_q), 128'(0));
        check(seg_wdata == '0, "R10 seg cleared", 128'(seg_wdata), 128'(0));
        send_word(128'h81, 8, 2'b10, 2'b10, 1'b0, -1, 1'b1);

        check(q.size() == 0, "R6 all words seen", 128'(q.size()), 128'(0));
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule